// File: doc/BRIEF.md
# I2C register-access target

This block is the serial front end of a small peripheral. It sits on a two-wire I2C bus as a target and gives a host byte-wide access to a register file that lives next to it. The block watches the oversampled bus lines for START and STOP conditions. It compares the first byte after START with its own 7-bit address. It treats the next written byte as a register pointer and then moves data between the bus and a plain register port. That port has an address, write data, a one-cycle write strobe, read data and a one-cycle read strobe. SDA is driven only through an open-drain pull-down output.

The target address comes from a two-bit strap code taken once as reset is released. The code tells where the board ties the address strap: 00 ground, 01 supply, 10 SCL, 11 SDA. These codes select the address bytes 0x40, 0x42, 0x50 and 0x52 in that order. A read is done with address+write, the command byte, a repeated START, address+read, and then data bytes. The host ends the read by NACKing the last byte and then sends STOP. After every data byte the pointer steps by one. The register file sees a read strobe exactly once for each byte that is loaded for transmission, so side effects caused by a read happen once per byte.

The controller has twelve states. The receive path is IDLE -> ADDR -> ADDR_ACK. On a match, a write goes on to CMD -> CMD_ACK -> WDATA -> STORE -> WDATA_ACK -> WDATA, and a read goes on to LOAD -> RDATA -> RACK -> LOAD. On a mismatch, or after a NACK from the host, the block enters SKIP. STOP from any state goes to IDLE. START from any state goes to ADDR.

Top module: `i2c_regport_target`

## Requirements
- R1: The address byte ({7-bit address, direction}) is ACKed only when bits 7..1 equal 0x20, 0x21, 0x28 or 0x29 for strap code 00, 01, 10 or 11 respectively.
- R2: After an address mismatch, SDA stays released and no register strobe occurs until the next START or STOP.
- R3: START (SDA falling while SCL high) restarts the address phase from any state, including a repeated START; STOP (SDA rising while SCL high) returns the block to idle.
- R4: In a write transfer the byte after the address loads the pointer, and each following byte appears on the register port with the write strobe high for one clock, the address equal to the pointer and the write data equal to the byte.
- R5: Every byte written to a selected target is ACKed in the ninth clock, including bytes aimed at read-only or undefined offsets, and the target changes its SDA drive only while SCL is low.
- R6: The pointer advances by one after every data byte, written or read, and a read that has no command byte starts at the current pointer.
- R7: Read data is sent MSB first, and the read strobe pulses for one clock each time a byte is loaded for transmission, never together with the write strobe.
- R8: A host ACK after a read byte makes the block load the next byte; a host NACK ends the transfer with no further read strobe.
- R9: Offsets 0x00 to 0x15 are defined. Reading a higher offset returns 0x00 without a read strobe. Writing a higher offset, or one of the read-only offsets 0x00, 0x01, 0x0E and 0x0F, issues no write strobe.
- R10: The strap code is taken only in the first clock after reset release; later changes of the code do not move the address.
- R11: During and right after reset, SDA is released and both register strobes are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, many times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| strap_code | input | 2 | Pre-decoded address strap: 00 ground, 01 supply, 10 SCL, 11 SDA |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_addr_o | output | 8 | Register offset (the pointer) |
| reg_wdata_o | output | 8 | Byte to write |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_re_o | output | 1 | One-cycle read strobe; read data is sampled in the same cycle |
| reg_rdata_i | input | 8 | Read data for reg_addr_o, combinational from the register file |

## Verification
The hardest cases to reach from the ports are the ones where the target drives the wire itself. These are the ACK slot, read data bits, and the release of SDA between them. They must never look like a START or STOP, and a host NACK must stop the read strobes. The bench models the bus as a wired AND of its own master drive and the target's pull-down. It walks real transfers through every strap code and every candidate address. It sweeps every offset from 0x00 to 0x17 with both writes and reads, covering read-only and undefined offsets. It adds ACKed bursts, a mismatch followed by a repeated START, and a STOP cut into a write. The bench counts strobes per offset against the values the requirements predict.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WDATA,
        ST_STORE,
        ST_WDATA_ACK,
        ST_LOAD,
        ST_RDATA,
        ST_RACK,
        ST_SKIP
    } i2ct_state_e;

    // strap code -> 7-bit target address (00:0x20 01:0x21 10:0x28 11:0x29)
    function automatic logic [6:0] strap_to_addr(input logic [1:0] code);
        return {3'b010, code[1], 2'b00, code[0]};
    endfunction

endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    // idle bus level is high, so the chain resets to ones
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-2:0], d};
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/i2ct_cond.sv
module i2ct_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_prev, sda_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_s;
            sda_prev <= sda_s;
        end
    end

    assign scl_rise  = ~scl_prev & scl_s;
    assign scl_fall  = scl_prev & ~scl_s;
    assign start_det = scl_prev & scl_s & sda_prev & ~sda_s;
    assign stop_det  = scl_prev & scl_s & ~sda_prev & sda_s;
endmodule

// File: rtl/i2ct_strap.sv
module i2ct_strap
    import i2ct_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] strap_code,
    output logic [6:0] own_addr
);
    logic taken;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            taken    <= 1'b0;
            own_addr <= strap_to_addr(2'b00);
        end else if (!taken) begin
            taken    <= 1'b1;
            own_addr <= strap_to_addr(strap_code);
        end
    end

    AST_STRAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        taken |=> $stable(own_addr)); // R10
endmodule

// File: rtl/i2c_regport_target.sv
module i2c_regport_target
    import i2ct_pkg::*;
#(
    parameter int                 SYNC_STAGES = 2,
    parameter int                 LAST_OFFSET = 21,
    parameter logic [LAST_OFFSET:0] RO_MAP    = 22'h00C003
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [1:0] strap_code,
    output logic       sda_pull_o,
    output logic [7:0] reg_addr_o,
    output logic [7:0] reg_wdata_o,
    output logic       reg_we_o,
    output logic       reg_re_o,
    input  logic [7:0] reg_rdata_i
);
    localparam logic [7:0] LAST_PTR = 8'(LAST_OFFSET);
    localparam logic [3:0] BITS     = 4'd8;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [6:0] own_addr;

    i2ct_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (.clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s));
    i2ct_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (.clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s));

    i2ct_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2ct_strap u_strap (.clk(clk), .rst_n(rst_n), .strap_code(strap_code), .own_addr(own_addr));

    i2ct_state_e state, nxt;
    logic [7:0]  shreg, tx, ptr;
    logic [3:0]  bitcnt;
    logic        rw_q, mack_q;
    logic        bit_full, in_range, ro_hit;

    assign bit_full = (bitcnt == BITS);
    assign in_range = (ptr <= LAST_PTR);

    always_comb begin
        ro_hit = 1'b0;
        for (int i = 0; i <= LAST_OFFSET; i++) begin
            if (RO_MAP[i] && ptr == 8'(i)) ro_hit = 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        if (stop_det)       nxt = ST_IDLE;
        else if (start_det) nxt = ST_ADDR;
        else begin
            unique case (state)
                ST_IDLE, ST_SKIP: nxt = state;
                ST_ADDR:      if (scl_fall && bit_full)
                                  nxt = (shreg[7:1] == own_addr) ? ST_ADDR_ACK : ST_SKIP;
                ST_ADDR_ACK:  if (scl_fall) nxt = rw_q ? ST_LOAD : ST_CMD;
                ST_CMD:       if (scl_fall && bit_full) nxt = ST_CMD_ACK;
                ST_CMD_ACK:   if (scl_fall) nxt = ST_WDATA;
                ST_WDATA:     if (scl_fall && bit_full) nxt = ST_STORE;
                ST_STORE:     nxt = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) nxt = ST_WDATA;
                ST_LOAD:      nxt = ST_RDATA;
                ST_RDATA:     if (scl_fall && bit_full) nxt = ST_RACK;
                ST_RACK:      if (scl_fall) nxt = mack_q ? ST_LOAD : ST_SKIP;
                default:      nxt = ST_IDLE;
            endcase
        end
    end

    // shift registers, bit counter, pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg  <= '0;
            tx     <= '0;
            ptr    <= '0;
            bitcnt <= '0;
            rw_q   <= 1'b0;
            mack_q <= 1'b0;
        end else if (start_det) begin
            bitcnt <= '0;
        end else begin
            unique case (state)
                ST_ADDR, ST_CMD, ST_WDATA: begin
                    if (scl_rise) begin
                        shreg  <= {shreg[6:0], sda_s};
                        bitcnt <= bitcnt + 4'd1;
                    end
                    if (scl_fall && bit_full) begin
                        if (state == ST_ADDR) rw_q <= shreg[0];
                        if (state == ST_CMD)  ptr  <= shreg;
                    end
                end
                ST_ADDR_ACK, ST_CMD_ACK: if (scl_fall) bitcnt <= '0;
                ST_WDATA_ACK: if (scl_fall) begin
                    bitcnt <= '0;
                    ptr    <= ptr + 8'd1;
                end
                ST_LOAD: begin
                    tx     <= in_range ? reg_rdata_i : 8'h00;
                    bitcnt <= '0;
                end
                ST_RDATA: begin
                    if (scl_rise) bitcnt <= bitcnt + 4'd1;
                    if (scl_fall) begin
                        if (bit_full) ptr <= ptr + 8'd1;
                        else          tx  <= {tx[6:0], 1'b0};
                    end
                end
                ST_RACK: if (scl_rise) mack_q <= ~sda_s;
                ST_IDLE, ST_STORE, ST_SKIP: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_pull_o  = 1'b0;
        reg_we_o    = 1'b0;
        reg_re_o    = 1'b0;
        reg_addr_o  = ptr;
        reg_wdata_o = shreg;
        unique case (state)
            ST_ADDR_ACK, ST_CMD_ACK, ST_WDATA_ACK: sda_pull_o = 1'b1;
            ST_RDATA: sda_pull_o = ~tx[7];
            ST_STORE: reg_we_o   = in_range && !ro_hit;
            ST_LOAD:  reg_re_o   = in_range;
            default: ;
        endcase
    end

    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |=> !reg_we_o); // R4
    AST_RE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re_o |=> !reg_re_o); // R7
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we_o && reg_re_o)); // R7
    AST_WE_DEFINED: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |-> (reg_addr_o <= LAST_PTR)); // R9
    AST_RE_DEFINED: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re_o |-> (reg_addr_o <= LAST_PTR)); // R9
    AST_SDA_HOLD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(scl_s) && $past(scl_s, 2) && !$past(start_det) && !$past(stop_det))
        |-> $stable(sda_pull_o)); // R5
endmodule

// File: tb/i2c_regport_target_bench.sv
module i2c_regport_target_bench;
    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic [1:0] strap = 2'b00;
    logic       sda_pull, reg_we, reg_re;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic       sda_line;

    int checks = 0, errors = 0;
    int we_total = 0, re_total = 0;
    int re_cnt [0:31];
    logic [7:0] mem [0:21];
    logic mem_init = 1'b0;

    always #10 clk = ~clk;

    assign sda_line  = sda_m & ~sda_pull;
    assign reg_rdata = (reg_addr <= 8'd21) ? mem[reg_addr[4:0]] : 8'hEE;

    i2c_regport_target u_i2c_regport_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .strap_code(strap), .sda_pull_o(sda_pull),
        .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata),
        .reg_we_o(reg_we), .reg_re_o(reg_re), .reg_rdata_i(reg_rdata)
    );

    function automatic logic [7:0] init_val(input int i);
        return 8'hA0 ^ 8'(i);
    endfunction

    function automatic bit writable(input int o);
        return o <= 21 && o != 0 && o != 1 && o != 14 && o != 15;
    endfunction

    always @(posedge clk) begin
        if (mem_init) begin
            for (int i = 0; i < 22; i++) mem[i] <= init_val(i);
            for (int i = 0; i < 32; i++) re_cnt[i] <= 0;
            we_total <= 0;
            re_total <= 0;
        end else begin
            if (reg_we) begin
                we_total <= we_total + 1;
                if (reg_addr <= 8'd21) mem[reg_addr[4:0]] <= reg_wdata;
            end
            if (reg_re) begin
                re_total <= re_total + 1;
                if (reg_addr < 8'd32) re_cnt[reg_addr[4:0]] <= re_cnt[reg_addr[4:0]] + 1;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic [1:0] code);
        rst_n = 1'b0; strap = code; scl_m = 1'b1; sda_m = 1'b1;
        tick(4);
        rst_n = 1'b1;
        tick(4);
    endtask

    task automatic clear_model();
        mem_init = 1'b1; tick(1); mem_init = 1'b0; tick(1);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2 * Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(2 * Q); scl_m = 1'b0; tick(Q);
        end
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        ack = ~sda_line;
        tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q); scl_m = 1'b1; tick(Q); b[i] = sda_line; tick(Q); scl_m = 1'b0; tick(Q);
        end
        sda_m = ~give_ack; tick(Q); scl_m = 1'b1; tick(2 * Q); scl_m = 1'b0; tick(Q);
        sda_m = 1'b1;
    endtask

    function automatic logic [6:0] addr_of(input int code);
        return {3'b010, 1'(code >> 1), 2'b00, 1'(code)};
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic       ack;
        logic [7:0] rd;
        int         re_before, we_before;
        logic [6:0] me;

        // R1, R11: every strap code against every candidate address
        for (int s = 0; s < 4; s++) begin
            do_reset(2'(s));
            check("R11 reset drive", {29'd0, sda_pull, reg_we, reg_re}, 0);
            for (int c = 0; c < 4; c++) begin
                i2c_start();
                send_byte({addr_of(c), 1'b0}, ack);
                i2c_stop();
                check("R1 address ack", int'(ack), int'(c == s));
            end
        end

        do_reset(2'b10);
        me = addr_of(2);
        clear_model();

        // R4, R5, R9: single-byte writes to every offset
        for (int o = 0; o < 24; o++) begin
            i2c_start();
            send_byte({me, 1'b0}, ack);
            check("R5 addr ack", int'(ack), 1);
            send_byte(8'(o), ack);
            check("R5 cmd ack", int'(ack), 1);
            send_byte(8'(o * 3 + 17), ack);
            check("R5 data ack", int'(ack), 1);
            i2c_stop();
        end
        for (int o = 0; o < 22; o++)
            check("R4 R9 stored", int'(mem[o]), writable(o) ? (o * 3 + 17) : int'(init_val(o)));
        check("R9 write strobes", we_total, 18);

        // R7, R9: single-byte reads of every offset
        for (int o = 0; o < 24; o++) begin
            i2c_start();
            send_byte({me, 1'b0}, ack);
            send_byte(8'(o), ack);
            i2c_start();
            send_byte({me, 1'b1}, ack);
            check("R7 read addr ack", int'(ack), 1);
            recv_byte(1'b0, rd);
            i2c_stop();
            check("R7 R9 read value", int'(rd), (o <= 21) ? int'(mem[o]) : 0);
        end
        for (int o = 0; o < 24; o++)
            check("R7 R9 read strobes", re_cnt[o], (o <= 21) ? 1 : 0);

        // R6: burst write
        i2c_start();
        send_byte({me, 1'b0}, ack);
        send_byte(8'h04, ack);
        for (int k = 0; k < 3; k++) send_byte(8'h5A + 8'(k), ack);
        i2c_stop();
        for (int k = 0; k < 3; k++) check("R6 burst write", int'(mem[4 + k]), 8'h5A + k);

        // R6, R8: burst read, host ACKs three then NACKs
        re_before = re_total;
        i2c_start();
        send_byte({me, 1'b0}, ack);
        send_byte(8'h03, ack);
        i2c_start();
        send_byte({me, 1'b1}, ack);
        for (int k = 0; k < 4; k++) begin
            recv_byte(k < 3, rd);
            check("R6 burst read", int'(rd), int'(mem[3 + k]));
        end
        i2c_stop();
        tick(20);
        check("R8 strobes after nack", re_total - re_before, 4);

        // R6: read without command continues at pointer 7
        i2c_start();
        send_byte({me, 1'b1}, ack);
        recv_byte(1'b0, rd);
        i2c_stop();
        check("R6 pointer carry", int'(rd), int'(mem[7]));

        // R2: foreign address followed by data
        we_before = we_total;
        re_before = re_total;
        i2c_start();
        send_byte({addr_of(1), 1'b0}, ack);
        check("R2 foreign addr", int'(ack), 0);
        send_byte(8'h05, ack);
        check("R2 no ack cmd", int'(ack), 0);
        send_byte(8'hFF, ack);
        check("R2 no ack data", int'(ack), 0);
        i2c_stop();
        check("R2 no strobes", (we_total - we_before) + (re_total - re_before), 0);
        check("R2 mem kept", int'(mem[5]), 8'h5B);

        // R3: repeated START recovers from a mismatch
        i2c_start();
        send_byte({addr_of(0), 1'b0}, ack);
        i2c_start();
        send_byte({me, 1'b0}, ack);
        check("R3 restart ack", int'(ack), 1);
        send_byte(8'h08, ack);
        send_byte(8'h77, ack);
        i2c_stop();
        check("R3 restart write", int'(mem[8]), 8'h77);

        // R3: STOP right after the command byte, pointer kept for the next read
        i2c_start();
        send_byte({me, 1'b0}, ack);
        send_byte(8'h09, ack);
        i2c_stop();
        i2c_start();
        send_byte({me, 1'b1}, ack);
        recv_byte(1'b0, rd);
        i2c_stop();
        check("R3 stop then read", int'(rd), int'(mem[9]));

        // R10: strap change after reset has no effect
        strap = 2'b00;
        tick(10);
        i2c_start();
        send_byte({me, 1'b0}, ack);
        i2c_stop();
        check("R10 old address", int'(ack), 1);
        i2c_start();
        send_byte({addr_of(0), 1'b0}, ack);
        i2c_stop();
        check("R10 new code ignored", int'(ack), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule